// File: doc/BRIEF.md
# Legacy DMA Controller Host Register File

This block is the host-facing register file of a four-channel DMA controller in the classic byte-wide style. A host reaches it over an 8-bit port bus with a 4-bit offset, a write strobe and a read strobe. Each channel keeps a 16-bit address and a 16-bit word count, each as a base copy and a current copy. A single byte-pointer flip-flop, shared by every channel, picks the low or high half for each byte-wide access to these registers.

The block also holds the controller-wide command, request, mask, status and temporary registers, plus a 6-bit mode field for each channel. It decodes two special commands. One clears the byte pointer. The other is a master clear that returns the control state to idle with every channel masked. The command, request, mask, mode and base values are driven out to the transfer engine, which sits outside this block.

Top module: `dmac_regfile`

## Requirements
- R1: A write to a channel port (offset bit 3 = 0; channel = offset[2:1]; offset[0]=0 selects the address register and offset[0]=1 selects the count register) puts the data byte into both the base copy and the current copy of that register. It goes into bits 7:0 when the byte pointer is 0 and into bits 15:8 when it is 1. Channel n's base values appear on `base_addr_o` and `base_cnt_o` at bits [16n+15:16n].
- R2: A read of a channel port returns, on `rdata` in the same cycle, the byte of the current register that the byte pointer selects.
- R3: The byte pointer is shared by all channels and all channel ports. It inverts after every read or write of a channel port.
- R4: A write of any value to offset 0xC sets the byte pointer to 0.
- R5: A read at offset 0x8 returns the status register, which is 0x00 after reset. A write at 0x8 loads `cmd_o`. A write at 0x9 loads `req_o`.
- R6: A write to offset 0xD clears the command, request, status and temporary registers and the byte pointer, and sets the mask to 4'hF. It leaves the channel address, count and mode registers as they were.
- R7: A write at offset 0xB stores data[7:2] into the mode field of channel data[1:0]. The field for channel n is on `mode_o` at bits [6n+5:6n].
- R8: A write at offset 0xA sets mask bit data[1:0] when data[2]=1 and clears that bit when data[2]=0. The other mask bits are unchanged.
- R9: A write at offset 0xE clears all four mask bits. A write at offset 0xF loads the mask from data[3:0].
- R10: A read of a write-only offset (0x9, 0xA, 0xB, 0xC, 0xE, 0xF) returns 0x00 and leaves the byte pointer unchanged.
- R11: After reset, all channel registers are zero, the command and request registers are 0, the byte pointer is 0 and the mask is 4'hF.
- R12: A read at offset 0xD returns the temporary register, which is 0x00 after reset or after a master clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Port offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when no read |
| cmd_o | output | 8 | Command register |
| req_o | output | 8 | Request register |
| mask_o | output | 4 | Channel mask bits, 1 = masked |
| mode_o | output | 24 | Per-channel mode fields |
| base_addr_o | output | 64 | Per-channel base address |
| base_cnt_o | output | 64 | Per-channel base word count |

## Verification
The bench aims at the shared pointer. It writes the low byte of one channel's count and then reads another channel's address. A design that keeps a pointer per channel would return the wrong half there. It clears the pointer partway through a pair and reads non-channel ports between the two halves of a write. A design that toggles on every access, or ignores the clear, would swap the bytes. It also checks that a master clear masks every channel but leaves the channel and mode contents intact, which catches a design that clears too much or too little.

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
  parameter int NCH = 4,
  parameter int RW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        cmd_o,
  output logic [7:0]        req_o,
  output logic [NCH-1:0]    mask_o,
  output logic [6*NCH-1:0]  mode_o,
  output logic [RW*NCH-1:0] base_addr_o,
  output logic [RW*NCH-1:0] base_cnt_o
);
  localparam int CW = $clog2(NCH);

  logic [RW-1:0] b_addr [NCH];
  logic [RW-1:0] c_addr [NCH];
  logic [RW-1:0] b_cnt  [NCH];
  logic [RW-1:0] c_cnt  [NCH];
  logic [5:0]    mode_q [NCH];
  logic [7:0]    cmd_q, req_q, stat_q, temp_q;
  logic [NCH-1:0] mask_q;
  logic          byte_ptr;

  wire          chan_port = ~addr[3];
  wire [CW-1:0] chan_sel  = addr[CW:1];
  wire          is_cnt    = addr[0];
  wire          chan_acc  = chan_port & (wr_en | rd_en);
  wire          do_mclr   = wr_en && addr == 4'hD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        b_addr[i] <= '0; c_addr[i] <= '0;
        b_cnt[i]  <= '0; c_cnt[i]  <= '0;
        mode_q[i] <= '0;
      end
      cmd_q <= '0; req_q <= '0; stat_q <= '0; temp_q <= '0;
      mask_q <= '1; byte_ptr <= 1'b0;
    end else begin
      if (chan_acc) byte_ptr <= ~byte_ptr;
      if (wr_en) begin
        if (chan_port) begin
          if (is_cnt) begin
            if (byte_ptr) begin
              b_cnt[chan_sel][15:8] <= wdata; c_cnt[chan_sel][15:8] <= wdata;
            end else begin
              b_cnt[chan_sel][7:0]  <= wdata; c_cnt[chan_sel][7:0]  <= wdata;
            end
          end else begin
            if (byte_ptr) begin
              b_addr[chan_sel][15:8] <= wdata; c_addr[chan_sel][15:8] <= wdata;
            end else begin
              b_addr[chan_sel][7:0]  <= wdata; c_addr[chan_sel][7:0]  <= wdata;
            end
          end
        end else begin
          case (addr[2:0])
            3'h0: cmd_q <= wdata;
            3'h1: req_q <= wdata;
            3'h2: mask_q[wdata[CW-1:0]] <= wdata[2];
            3'h3: mode_q[wdata[CW-1:0]] <= wdata[7:2];
            3'h4: byte_ptr <= 1'b0;
            3'h5: begin
              cmd_q <= '0; req_q <= '0; stat_q <= '0; temp_q <= '0;
              mask_q <= '1; byte_ptr <= 1'b0;
            end
            3'h6: mask_q <= '0;
            default: mask_q <= wdata[NCH-1:0];
          endcase
        end
      end
    end
  end

  logic [RW-1:0] rd_word;
  assign rd_word = is_cnt ? c_cnt[chan_sel] : c_addr[chan_sel];

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (chan_port)          rdata = byte_ptr ? rd_word[15:8] : rd_word[7:0];
      else if (addr == 4'h8)  rdata = stat_q;
      else if (addr == 4'hD)  rdata = temp_q;
    end
  end

  assign cmd_o  = cmd_q;
  assign req_o  = req_q;
  assign mask_o = mask_q;

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign mode_o[6*g +: 6]       = mode_q[g];
    assign base_addr_o[RW*g +: RW] = b_addr[g];
    assign base_cnt_o[RW*g +: RW]  = b_cnt[g];
  end

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_acc |=> byte_ptr != $past(byte_ptr));

  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hC) |=> !byte_ptr);

  // R6
  mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_mclr |=> (mask_o == '1 && cmd_o == 8'h00 && req_o == 8'h00 && !byte_ptr));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr[3]) |=> $stable(byte_ptr));

  // R7
  mode_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h8) |=> $stable(mode_o));
endmodule

// File: tb/dmac_regfile_tb_top.sv
`timescale 1ns/1ps
module dmac_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, cmd_o, req_o;
  logic [3:0]  mask_o;
  logic [23:0] mode_o;
  logic [63:0] base_addr_o, base_cnt_o;

  int applied = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  dmac_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cmd_o(cmd_o), .req_o(req_o),
    .mask_o(mask_o), .mode_o(mode_o), .base_addr_o(base_addr_o),
    .base_cnt_o(base_cnt_o));

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] e);
    applied++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #3;
      if (rd_en) begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, {56'b0, rdata}, {56'b0, e});
      end
    end
  end

  initial begin : watchdog
    #1000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 mask", {60'b0, mask_o}, 64'hF);
    chk("R11 cmd", {56'b0, cmd_o}, 64'h0);
    chk("R11 base_addr", base_addr_o, 64'h0);
    rd(4'h8, 8'h00, "R5 status after reset");
    rd(4'h0, 8'h00, "R11 ch0 addr lo");
    rd(4'h0, 8'h00, "R11 ch0 addr hi");
    // R1 R2 low then high
    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    chk("R1 base ch1 addr", {48'b0, base_addr_o[31:16]}, 64'h1234);
    rd(4'h2, 8'h34, "R2 ch1 addr lo");
    rd(4'h2, 8'h12, "R2 ch1 addr hi");
    // R3 shared pointer across channels
    wr(4'h3, 8'hCD);
    rd(4'h4, 8'h00, "R3 ch2 addr hi via shared ptr");
    rd(4'h3, 8'hCD, "R3 ch1 cnt lo");
    rd(4'h3, 8'h00, "R3 ch1 cnt hi");
    chk("R1 base ch1 cnt", {48'b0, base_cnt_o[31:16]}, 64'h00CD);
    // R4 clear mid-sequence
    wr(4'h6, 8'hAA); wr(4'hC, 8'h5F); wr(4'h6, 8'hBB); wr(4'h6, 8'h77);
    rd(4'h6, 8'hBB, "R4 ch3 addr lo");
    rd(4'h6, 8'h77, "R4 ch3 addr hi");
    // R10 write-only reads
    wr(4'h0, 8'h11);
    rd(4'hA, 8'h00, "R10 read 0xA");
    rd(4'hE, 8'h00, "R10 read 0xE");
    rd(4'hF, 8'h00, "R10 read 0xF");
    rd(4'h9, 8'h00, "R10 read 0x9");
    wr(4'h0, 8'h22);
    rd(4'h0, 8'h11, "R10 ch0 lo intact");
    rd(4'h0, 8'h22, "R10 ch0 hi after reads");
    // R5
    wr(4'h8, 8'h5A); wr(4'h9, 8'h06);
    chk("R5 cmd", {56'b0, cmd_o}, 64'h5A);
    chk("R5 req", {56'b0, req_o}, 64'h06);
    rd(4'h8, 8'h00, "R5 status read");
    // R7
    wr(4'hB, 8'b1011_0110);
    chk("R7 mode ch2", {58'b0, mode_o[17:12]}, 64'h2D);
    chk("R7 mode ch0", {58'b0, mode_o[5:0]}, 64'h0);
    // R8 R9
    wr(4'hF, 8'h00);
    chk("R9 mask load 0", {60'b0, mask_o}, 64'h0);
    wr(4'hA, 8'h05);
    chk("R8 mask set ch1", {60'b0, mask_o}, 64'h2);
    wr(4'hA, 8'h07);
    chk("R8 mask set ch3", {60'b0, mask_o}, 64'hA);
    wr(4'hA, 8'h01);
    chk("R8 mask clr ch1", {60'b0, mask_o}, 64'h8);
    wr(4'hF, 8'h0A);
    chk("R9 mask load A", {60'b0, mask_o}, 64'hA);
    wr(4'hE, 8'hFF);
    chk("R9 mask reset", {60'b0, mask_o}, 64'h0);
    // R6 R12 master clear
    wr(4'h0, 8'h99);
    wr(4'hD, 8'h00);
    chk("R6 mask", {60'b0, mask_o}, 64'hF);
    chk("R6 cmd", {56'b0, cmd_o}, 64'h0);
    chk("R6 req", {56'b0, req_o}, 64'h0);
    chk("R6 mode kept", {58'b0, mode_o[17:12]}, 64'h2D);
    rd(4'hD, 8'h00, "R12 temp read");
    rd(4'h8, 8'h00, "R6 status cleared");
    rd(4'h0, 8'h99, "R6 ptr cleared, ch0 lo");
    rd(4'h0, 8'h22, "R6 ch0 hi kept");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule